// File: doc/BRIEF.md
# Pointer Page-Permission Shadow Fill

This block keeps a shadow of page permissions for every general register that can serve as a load/store base. Each entry covers two 8 KB pages. One is the page the register's pointer value falls in. The other is the adjacent page on the side that address bit 12 points to: the next page when bit 12 is one, the previous page when it is zero. A decode-stage precheck reads an entry on a combinational port. From it the precheck can tell, before any offset is added, whether a load or store with a short signed displacement may touch either page.

When a pointer-producing instruction writes a register, the block records the new page number and direction. The entry is then marked not valid and the write completes at once. Two translation lookups go out in the background, on a shared valid/ready request channel: first the current page, then the neighbour page in the very next request slot. Lookup answers come back on a response channel that the block always accepts, one per cycle. Each answer carries the register index, a sequence tag and which of the two pages it answers. Only read and write permission are kept, and a page that failed to translate is kept as both denied. The entry becomes valid once both answers of its latest fill have arrived. Answers whose tag belongs to an earlier fill of the same register are dropped.

Request channel rules: a request is transferred on a clock edge where `lk_req_valid` and `lk_req_ready` are both high. While `lk_req_valid` is high and `lk_req_ready` is low, the request payload does not change and the request is not withdrawn. The write port and the response port have no back-pressure.

Top module: `psf_shadow_fill`

## Requirements
- R1: A pointer write (`wr_valid`) is accepted on every cycle it is presented, without stalling. Back-to-back writes to different registers each produce a complete fill.
- R2: The first lookup of a fill requests the current page number, which is the pointer shifted right by 13 (`lk_req_nbr` = 0).
- R3: The second lookup of a fill requests the neighbour page number (`lk_req_nbr` = 1): the current page number plus one if pointer bit 12 is 1, minus one if it is 0, wrapping modulo the page-number width. It is presented in the cycle right after the current-page request is accepted.
- R4: A response with `lk_rsp_mapped` = 0 is stored as read denied and write denied, whatever the permission bits it carries. A mapped response stores `lk_rsp_rd` and `lk_rsp_wr` as given.
- R5: A register's entry reads not valid from the cycle after it is written until both responses of its latest fill have been taken. After that it reads valid.
- R6: A rewrite of a register whose fill is still outstanding cancels that fill. Responses carrying an older tag leave the entry unchanged, and the entry ends up holding the newest pointer's permissions.
- R7: While `lk_req_valid` is high and `lk_req_ready` is low, the request stays asserted with stable payload.
- R8: After reset, every entry reads not valid and no request is presented.
- R9: The precheck port returns, combinationally for any `pc_idx`, the valid flag, the direction bit (pointer bit 12) and both permission pairs. A fill of one register does not change any other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Pointer-producing write this cycle |
| wr_idx | input | IW | Register being written |
| wr_ptr | input | AW | New pointer value |
| lk_req_valid | output | 1 | Lookup request valid |
| lk_req_ready | input | 1 | Lookup channel can take the request |
| lk_req_vpn | output | VW | Page number to translate |
| lk_req_idx | output | IW | Register the request belongs to |
| lk_req_tag | output | TW | Fill sequence tag |
| lk_req_nbr | output | 1 | 0 current page, 1 neighbour page |
| lk_rsp_valid | input | 1 | Lookup response valid (always accepted) |
| lk_rsp_idx | input | IW | Echoed register index |
| lk_rsp_tag | input | TW | Echoed sequence tag |
| lk_rsp_nbr | input | 1 | Echoed page select |
| lk_rsp_mapped | input | 1 | Translation found |
| lk_rsp_rd | input | 1 | Read allowed |
| lk_rsp_wr | input | 1 | Write allowed |
| pc_idx | input | IW | Register the precheck inspects |
| pc_valid | output | 1 | Entry holds a complete fill |
| pc_up | output | 1 | Neighbour is the following page |
| pc_cur_rd | output | 1 | Current page readable |
| pc_cur_wr | output | 1 | Current page writable |
| pc_nbr_rd | output | 1 | Neighbour page readable |
| pc_nbr_wr | output | 1 | Neighbour page writable |

## Verification
A write sampled at edge N clears the entry at once. Its current-page request can be loaded into the output register at edge N+1 when the slot is free. The neighbour request is loaded at the same edge that accepts the current one. A response presented before an edge updates the entry at that edge, and the precheck port reflects it combinationally. The bench drives on falling edges and samples after them, so each result is read one half period after the edge that makes it. A scoreboard queue holds the page numbers each write is due to request and matches every accepted request against it. Permission and validity checks are made only after the response queue has drained or after a fixed release of single responses, so no check depends on exact arbitration latency.

// File: rtl/psf_pkg.sv
`timescale 1ns/1ps
package psf_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } perm_t;
endpackage

// File: rtl/psf_entry_table.sv
`timescale 1ns/1ps
module psf_entry_table #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int PS   = 13,
  parameter int TW   = 3,
  localparam int IW  = $clog2(NREG),
  localparam int VW  = AW - PS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [IW-1:0]             wr_idx,
  input  logic [AW-1:0]             wr_ptr,
  input  logic                      gnt_valid,
  input  logic [IW-1:0]             gnt_idx,
  input  logic                      gnt_nbr,
  input  logic                      rsp_valid,
  input  logic [IW-1:0]             rsp_idx,
  input  logic [TW-1:0]             rsp_tag,
  input  logic                      rsp_nbr,
  input  logic                      rsp_mapped,
  input  logic                      rsp_rd,
  input  logic                      rsp_wr,
  output logic [NREG-1:0]           need_cur,
  output logic [NREG-1:0]           need_nbr,
  output logic [NREG-1:0][VW-1:0]   vpn_arr,
  output logic [NREG-1:0]           up_arr,
  output logic [NREG-1:0][TW-1:0]   tag_arr,
  input  logic [IW-1:0]             rd_idx,
  output logic                      rd_valid,
  output logic                      rd_up,
  output psf_pkg::perm_t            rd_cur,
  output psf_pkg::perm_t            rd_nbr
);
  import psf_pkg::*;

  logic  [NREG-1:0] valid_v;
  perm_t [NREG-1:0] cur_v;
  perm_t [NREG-1:0] nbr_v;

  perm_t rsp_perm;
  assign rsp_perm = rsp_mapped ? perm_t'{rd: rsp_rd, wr: rsp_wr} : perm_t'('0);

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic [VW-1:0] vpn_q;
    logic          up_q;
    logic [TW-1:0] tag_q;
    logic          ncur_q, nnbr_q, gcur_q, gnbr_q;
    perm_t         cur_q, nbr_q;
    logic          wr_hit, gnt_hit, rsp_hit, rsp_stale;

    assign wr_hit    = wr_valid && (wr_idx == IW'(i));
    assign gnt_hit   = gnt_valid && (gnt_idx == IW'(i));
    assign rsp_hit   = rsp_valid && (rsp_idx == IW'(i)) && (rsp_tag == tag_q);
    assign rsp_stale = rsp_valid && (rsp_idx == IW'(i)) && (rsp_tag != tag_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vpn_q  <= '0;
        up_q   <= 1'b0;
        tag_q  <= '0;
        ncur_q <= 1'b0;
        nnbr_q <= 1'b0;
        gcur_q <= 1'b0;
        gnbr_q <= 1'b0;
        cur_q  <= '0;
        nbr_q  <= '0;
      end else if (wr_hit) begin
        vpn_q  <= wr_ptr[AW-1:PS];
        up_q   <= wr_ptr[PS-1];
        tag_q  <= tag_q + TW'(1);
        ncur_q <= 1'b1;
        nnbr_q <= 1'b1;
        gcur_q <= 1'b0;
        gnbr_q <= 1'b0;
        cur_q  <= '0;
        nbr_q  <= '0;
      end else begin
        if (gnt_hit && !gnt_nbr) ncur_q <= 1'b0;
        if (gnt_hit &&  gnt_nbr) nnbr_q <= 1'b0;
        if (rsp_hit && !rsp_nbr) begin
          cur_q  <= rsp_perm;
          gcur_q <= 1'b1;
        end
        if (rsp_hit && rsp_nbr) begin
          nbr_q  <= rsp_perm;
          gnbr_q <= 1'b1;
        end
      end
    end

    assign need_cur[i] = ncur_q;
    assign need_nbr[i] = nnbr_q;
    assign vpn_arr[i]  = vpn_q;
    assign up_arr[i]   = up_q;
    assign tag_arr[i]  = tag_q;
    assign valid_v[i]  = gcur_q && gnbr_q;
    assign cur_v[i]    = cur_q;
    assign nbr_v[i]    = nbr_q;

    AST_WR_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> !(gcur_q || gnbr_q)); // R5
    AST_UNMAPPED_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit && !rsp_nbr && !rsp_mapped && !wr_hit) |=> (cur_q == '0) && gcur_q); // R4
    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_stale && !wr_hit) |=> $stable(cur_q) && $stable(nbr_q) && $stable(gcur_q) && $stable(gnbr_q)); // R6
  end

  assign rd_valid = valid_v[rd_idx];
  assign rd_up    = up_arr[rd_idx];
  assign rd_cur   = cur_v[rd_idx];
  assign rd_nbr   = nbr_v[rd_idx];
endmodule

// File: rtl/psf_req_issue.sv
`timescale 1ns/1ps
module psf_req_issue #(
  parameter int NREG = 16,
  parameter int VW   = 19,
  parameter int TW   = 3,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0]         need_cur,
  input  logic [NREG-1:0]         need_nbr,
  input  logic [NREG-1:0][VW-1:0] vpn_arr,
  input  logic [NREG-1:0]         up_arr,
  input  logic [NREG-1:0][TW-1:0] tag_arr,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [VW-1:0]           req_vpn,
  output logic [IW-1:0]           req_idx,
  output logic [TW-1:0]           req_tag,
  output logic                    req_nbr,
  output logic                    gnt_valid,
  output logic [IW-1:0]           gnt_idx,
  output logic                    gnt_nbr
);
  logic          cand_v, cand_nbr;
  logic [IW-1:0] cand_idx;
  logic          lock_v;
  logic [IW-1:0] lock_idx;
  logic [VW-1:0] base_vpn, cand_vpn;
  logic          load;

  always_comb begin
    cand_v   = 1'b0;
    cand_idx = '0;
    cand_nbr = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (need_cur[i] || need_nbr[i]) begin
        cand_v   = 1'b1;
        cand_idx = IW'(i);
        cand_nbr = !need_cur[i];
      end
    end
    if (lock_v && need_nbr[lock_idx]) begin
      cand_v   = 1'b1;
      cand_idx = lock_idx;
      cand_nbr = 1'b1;
    end
  end

  assign base_vpn = vpn_arr[cand_idx];
  assign cand_vpn = !cand_nbr ? base_vpn :
                    (up_arr[cand_idx] ? base_vpn + VW'(1) : base_vpn - VW'(1));
  assign load      = cand_v && (!req_valid || req_ready);
  assign gnt_valid = load;
  assign gnt_idx   = cand_idx;
  assign gnt_nbr   = cand_nbr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_vpn   <= '0;
      req_idx   <= '0;
      req_tag   <= '0;
      req_nbr   <= 1'b0;
      lock_v    <= 1'b0;
      lock_idx  <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_vpn   <= cand_vpn;
      req_idx   <= cand_idx;
      req_tag   <= tag_arr[cand_idx];
      req_nbr   <= cand_nbr;
      lock_v    <= !cand_nbr;
      lock_idx  <= cand_idx;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_vpn) && $stable(req_idx)
                                  && $stable(req_tag) && $stable(req_nbr)); // R7
  AST_NBR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_nbr) |=> req_valid && req_nbr && (req_idx == $past(req_idx))); // R3
endmodule

// File: rtl/psf_shadow_fill.sv
`timescale 1ns/1ps
module psf_shadow_fill #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int PS   = 13,
  parameter int TW   = 3,
  localparam int IW  = $clog2(NREG),
  localparam int VW  = AW - PS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_ptr,
  output logic          lk_req_valid,
  input  logic          lk_req_ready,
  output logic [VW-1:0] lk_req_vpn,
  output logic [IW-1:0] lk_req_idx,
  output logic [TW-1:0] lk_req_tag,
  output logic          lk_req_nbr,
  input  logic          lk_rsp_valid,
  input  logic [IW-1:0] lk_rsp_idx,
  input  logic [TW-1:0] lk_rsp_tag,
  input  logic          lk_rsp_nbr,
  input  logic          lk_rsp_mapped,
  input  logic          lk_rsp_rd,
  input  logic          lk_rsp_wr,
  input  logic [IW-1:0] pc_idx,
  output logic          pc_valid,
  output logic          pc_up,
  output logic          pc_cur_rd,
  output logic          pc_cur_wr,
  output logic          pc_nbr_rd,
  output logic          pc_nbr_wr
);
  import psf_pkg::*;

  logic [NREG-1:0]         need_cur, need_nbr, up_arr;
  logic [NREG-1:0][VW-1:0] vpn_arr;
  logic [NREG-1:0][TW-1:0] tag_arr;
  logic                    gnt_valid, gnt_nbr;
  logic [IW-1:0]           gnt_idx;
  perm_t                   rd_cur, rd_nbr;

  psf_entry_table #(.NREG(NREG), .AW(AW), .PS(PS), .TW(TW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_idx     (wr_idx),
    .wr_ptr     (wr_ptr),
    .gnt_valid  (gnt_valid),
    .gnt_idx    (gnt_idx),
    .gnt_nbr    (gnt_nbr),
    .rsp_valid  (lk_rsp_valid),
    .rsp_idx    (lk_rsp_idx),
    .rsp_tag    (lk_rsp_tag),
    .rsp_nbr    (lk_rsp_nbr),
    .rsp_mapped (lk_rsp_mapped),
    .rsp_rd     (lk_rsp_rd),
    .rsp_wr     (lk_rsp_wr),
    .need_cur   (need_cur),
    .need_nbr   (need_nbr),
    .vpn_arr    (vpn_arr),
    .up_arr     (up_arr),
    .tag_arr    (tag_arr),
    .rd_idx     (pc_idx),
    .rd_valid   (pc_valid),
    .rd_up      (pc_up),
    .rd_cur     (rd_cur),
    .rd_nbr     (rd_nbr)
  );

  psf_req_issue #(.NREG(NREG), .VW(VW), .TW(TW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .need_cur  (need_cur),
    .need_nbr  (need_nbr),
    .vpn_arr   (vpn_arr),
    .up_arr    (up_arr),
    .tag_arr   (tag_arr),
    .req_valid (lk_req_valid),
    .req_ready (lk_req_ready),
    .req_vpn   (lk_req_vpn),
    .req_idx   (lk_req_idx),
    .req_tag   (lk_req_tag),
    .req_nbr   (lk_req_nbr),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .gnt_nbr   (gnt_nbr)
  );

  assign pc_cur_rd = rd_cur.rd;
  assign pc_cur_wr = rd_cur.wr;
  assign pc_nbr_rd = rd_nbr.rd;
  assign pc_nbr_wr = rd_nbr.wr;

  AST_WRITE_NO_REQ_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req_valid && !lk_req_ready) |=> lk_req_valid); // R7
endmodule

// File: tb/psf_shadow_fill_tb_top.sv
`timescale 1ns/1ps
module psf_shadow_fill_tb_top;
  localparam int NREG = 16, AW = 32, PS = 13, TW = 3;
  localparam int IW = $clog2(NREG), VW = AW - PS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, wr_valid, lk_req_valid, lk_req_ready, lk_req_nbr;
  logic [IW-1:0] wr_idx, lk_req_idx, lk_rsp_idx, pc_idx;
  logic [AW-1:0] wr_ptr;
  logic [VW-1:0] lk_req_vpn;
  logic [TW-1:0] lk_req_tag, lk_rsp_tag;
  logic          lk_rsp_valid, lk_rsp_nbr, lk_rsp_mapped, lk_rsp_rd, lk_rsp_wr;
  logic          pc_valid, pc_up, pc_cur_rd, pc_cur_wr, pc_nbr_rd, pc_nbr_wr;

  psf_shadow_fill #(.NREG(NREG), .AW(AW), .PS(PS), .TW(TW)) dut_i (.*);

  typedef struct {
    logic [IW-1:0] idx;
    logic [TW-1:0] tag;
    logic          nbr;
    logic [VW-1:0] vpn;
  } item_t;

  item_t exp_q[$];
  item_t pend_q[$];
  int    vectors = 0, miscmp = 0;
  int    rsp_budget = 1000000;
  bit    finished = 0;

  function automatic logic [VW-1:0] cur_vpn(logic [AW-1:0] p);
    return p[AW-1:PS];
  endfunction
  function automatic logic [VW-1:0] nbr_vpn(logic [AW-1:0] p);
    return p[PS-1] ? p[AW-1:PS] + VW'(1) : p[AW-1:PS] - VW'(1);
  endfunction
  function automatic logic is_mapped(logic [VW-1:0] v);
    return v[1:0] != 2'b11;
  endfunction
  function automatic logic [1:0] raw_perm(logic [VW-1:0] v);
    return {~v[3], v[2]};
  endfunction
  function automatic logic [1:0] exp_perm(logic [VW-1:0] v);
    return is_mapped(v) ? raw_perm(v) : 2'b00;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: responder then request monitor, both on the falling edge
  always @(negedge clk) begin : sb
    item_t r;
    int    hit;
    if (rst_n && rsp_budget > 0 && pend_q.size() > 0) begin
      r = pend_q.pop_front();
      lk_rsp_valid  = 1'b1;
      lk_rsp_idx    = r.idx;
      lk_rsp_tag    = r.tag;
      lk_rsp_nbr    = r.nbr;
      lk_rsp_mapped = is_mapped(r.vpn);
      {lk_rsp_rd, lk_rsp_wr} = raw_perm(r.vpn);
      rsp_budget--;
    end else begin
      lk_rsp_valid = 1'b0;
    end
    if (rst_n && lk_req_valid && lk_req_ready) begin
      hit = -1;
      foreach (exp_q[k])
        if (hit < 0 && exp_q[k].idx == lk_req_idx && exp_q[k].nbr == lk_req_nbr) hit = k;
      if (hit < 0) begin
        vectors++;
        miscmp++;
        $display("FAIL R2/R3 unexpected request actual=%0h expected=none",
                 {lk_req_idx, lk_req_nbr, lk_req_vpn});
      end else begin
        chk(lk_req_nbr ? "R3 neighbour page" : "R2 current page",
            64'(lk_req_vpn), 64'(exp_q[hit].vpn));
        exp_q.delete(hit);
      end
      r.idx = lk_req_idx; r.tag = lk_req_tag; r.nbr = lk_req_nbr; r.vpn = lk_req_vpn;
      pend_q.push_back(r);
    end
  end

  task automatic write_ptr(input int idx, input logic [AW-1:0] p);
    item_t e;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_idx   = IW'(idx);
    wr_ptr   = p;
    e.idx = IW'(idx); e.tag = '0; e.nbr = 1'b0; e.vpn = cur_vpn(p);
    exp_q.push_back(e);
    e.nbr = 1'b1; e.vpn = nbr_vpn(p);
    exp_q.push_back(e);
  endtask

  task automatic wr_idle();
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #2 lk_req_ready = v;
  endtask

  task automatic wait_quiet(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || pend_q.size() != 0 || lk_req_valid || lk_rsp_valid) && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({req, " fill completes"}, 64'(n >= 200), 64'(0));
    repeat (2) @(negedge clk);
  endtask

  task automatic check_shadow(input int idx, input logic [AW-1:0] p, input string req);
    @(negedge clk);
    pc_idx = IW'(idx);
    #2;
    chk(req, 64'({pc_valid, pc_up, pc_cur_rd, pc_cur_wr, pc_nbr_rd, pc_nbr_wr}),
        64'({1'b1, p[PS-1], exp_perm(cur_vpn(p)), exp_perm(nbr_vpn(p))}));
  endtask

  task automatic check_valid(input int idx, input logic v, input string req);
    @(negedge clk);
    pc_idx = IW'(idx);
    #2;
    chk(req, 64'(pc_valid), 64'(v));
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      miscmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] p0, p1, p2, pa, pb, pr;
    logic          all_inv;
    p0 = 32'h0000_5000; p1 = 32'h0001_C000; p2 = 32'h0000_0800;
    pa = 32'h0000_5000; pb = 32'h0000_8000; pr = 32'h00AB_3F00;
    rst_n = 1'b0; wr_valid = 1'b0; wr_idx = '0; wr_ptr = '0;
    lk_req_ready = 1'b1; pc_idx = '0;
    lk_rsp_valid = 1'b0; lk_rsp_idx = '0; lk_rsp_tag = '0; lk_rsp_nbr = 1'b0;
    lk_rsp_mapped = 1'b0; lk_rsp_rd = 1'b0; lk_rsp_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    @(negedge clk);
    chk("R8 no request after reset", 64'(lk_req_valid), 64'(0));
    all_inv = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      pc_idx = IW'(i);
      #1;
      if (pc_valid) all_inv = 1'b0;
    end
    chk("R8 all entries not valid", 64'(all_inv), 64'(1));

    // R2/R3/R4: single fills, bit 12 set (unmapped neighbour), clear, and wrap below zero
    write_ptr(0, p0); wr_idle(); wait_quiet("R2");
    check_shadow(0, p0, "R4 unmapped neighbour denied");
    write_ptr(1, p1); wr_idle(); wait_quiet("R3");
    check_shadow(1, p1, "R3 preceding neighbour");
    write_ptr(3, p2); wr_idle(); wait_quiet("R3");
    check_shadow(3, p2, "R3 wrap below page zero");

    // R1: writes on consecutive cycles, no stall
    write_ptr(4, 32'h1234_5678);
    write_ptr(5, 32'h0004_7000);
    write_ptr(6, 32'hFFFF_F000);
    write_ptr(7, 32'h0002_A123);
    wr_idle();
    wait_quiet("R1");
    check_shadow(4, 32'h1234_5678, "R1 burst entry 4");
    check_shadow(5, 32'h0004_7000, "R1 burst entry 5");
    check_shadow(6, 32'hFFFF_F000, "R3 wrap above top page");
    check_shadow(7, 32'h0002_A123, "R1 burst entry 7");

    // R5: valid only after both responses
    rsp_budget = 0;
    write_ptr(9, pr); wr_idle();
    repeat (6) @(negedge clk);
    check_valid(9, 1'b0, "R5 no response yet");
    rsp_budget = 1;
    repeat (3) @(negedge clk);
    check_valid(9, 1'b0, "R5 one response only");
    rsp_budget = 1;
    repeat (3) @(negedge clk);
    check_shadow(9, pr, "R5 both responses");
    rsp_budget = 1000000;
    wait_quiet("R5");

    // R6: rewrite while fill outstanding, stale responses dropped
    rsp_budget = 0;
    write_ptr(2, pa); wr_idle();
    repeat (6) @(negedge clk);
    write_ptr(2, pb); wr_idle();
    repeat (6) @(negedge clk);
    check_valid(2, 1'b0, "R6 pending after rewrite");
    rsp_budget = 1000000;
    wait_quiet("R6");
    check_shadow(2, pb, "R6 newest pointer kept");
    check_shadow(0, p0, "R9 other entry untouched");

    // R7: back-pressure on the request channel
    set_ready(1'b0);
    write_ptr(11, pr); wr_idle();
    repeat (4) @(negedge clk);
    chk("R7 request asserted under stall", 64'(lk_req_valid), 64'(1));
    chk("R7 payload under stall", 64'({lk_req_idx, lk_req_nbr, lk_req_vpn}),
        64'({4'd11, 1'b0, cur_vpn(pr)}));
    repeat (3) @(negedge clk);
    chk("R7 payload still held", 64'({lk_req_valid, lk_req_idx, lk_req_nbr, lk_req_vpn}),
        64'({1'b1, 4'd11, 1'b0, cur_vpn(pr)}));
    set_ready(1'b1);
    wait_quiet("R7");
    check_shadow(11, pr, "R7 fill after stall");
    check_shadow(9, pr, "R9 read of another index");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule